// File: doc/BRIEF.md
# Digit-Serial Offset Subtractor with Programmable Low-Digit Radix

This block builds a six-digit division number from two externally supplied numbers. It takes one digit of each number per fetch period, least significant digit first, and forms the difference minus a borrow-in. Both digit buses are active-low. The lowest digit is counted in a programmable radix M, from 1 to 16, and the five upper digits are decimal. The value is therefore `(d5·10^4 + d4·10^3 + d3·10^2 + d2·10 + d1)·M + d0`.

A single borrow flop carries the serial borrow chain between digit periods. When the difference is negative, the stored digits hold the value plus M·10^5. This is what the chain yields on its own when it wraps. The final borrow is presented as a borrow-out, so that cascaded units can pass it on. A configuration load in period 6 sets M for later subtractions. The block also reports the highest non-zero digit among d5 to d2, which is used to load a downstream counter.

Top module: `offset_subtractor`

## Requirements
- R1: After synchronous reset, every stored digit is 0, `borrow_out` is 0, `borrow_valid` is 0, `msd` is 0 and `msd_none` is 1. The digit-0 radix is 10.
- R2: The digit value used for each bus is the bitwise inverse of the 4-bit input (active-low digits).
- R3: A load in period k (1 to 5) stores `a − b − borrow` into digit k of `digits` (bits 4k+3:4k). When that is negative, 10 is added and a borrow passes to the next period.
- R4: A load in period 0 stores digit 0 in radix M. When `a − b − borrow_in` is negative, M is added and a borrow passes to period 1.
- R5: `borrow_in` is sampled only in the period-0 load. A value of 1 subtracts one more from the result.
- R6: When A − B − bin is negative, the six digits represent A − B − bin + M·10^5 and `borrow_out` is 1. Otherwise `borrow_out` is 0.
- R7: `borrow_valid` is set the cycle after a period-5 load and cleared the cycle after a period-0 load. `borrow_out` changes only on a period-5 load.
- R8: A load in period 6 sets M to the inverted A bus, with an inverted value of 0 (A bus all ones) meaning 16. The new M applies from the next period-0 load onward.
- R9: One cycle after the digits change, `msd` holds the highest non-zero digit among d5..d2. When those four digits are all zero, `msd` is 0 and `msd_none` is 1.
- R10: While `load` is low, the bus values have no effect on `digits` or `borrow_out`.
- R11: A load in period 7 changes no digit, no borrow state and not M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle load strobe from the fetch sequencer |
| period | input | 3 | Fetch period index (0-5 digits, 6 configuration, 7 idle) |
| a_n | input | 4 | Minuend digit, or radix code in period 6; active low |
| b_n | input | 4 | Subtrahend digit, active low |
| borrow_in | input | 1 | Borrow-in, used in period 0 |
| digits | output | 24 | Stored result digits, digit k at bits 4k+3:4k |
| msd | output | 4 | Highest non-zero digit among d5..d2 |
| msd_none | output | 1 | High when d5..d2 are all zero |
| borrow_out | output | 1 | Final borrow of the last subtraction |
| borrow_valid | output | 1 | borrow_out holds a completed result |

## Verification
The bench tests a borrow that ripples through every decimal digit and a fully negative result. A design that handled the wrap wrongly would give a wrong top digit or a missing `borrow_out`. It runs subtractions with M at 16 (bus all ones), at 3 and at the reset value 10. A design that used the decimal radix for digit 0, or that misread the all-ones code, would show a wrong d0. It also checks that loads in period 7 and idle bus activity are ignored. It checks that `borrow_valid` drops after a new period-0 load, which shows that a stale borrow is not reported as current. Finally, it checks the highest-digit search when d5..d2 are all zero.

// File: rtl/osub_pkg.sv
package osub_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 6;
  localparam int DEC_RADIX  = 10;
  localparam int CFG_PERIOD = 6;
  localparam int MSD_LOW    = 2;
endpackage

// File: rtl/osub_digit_step.sv
// One digit of the serial subtraction: a - b - borrow, wrapped into the given radix.
module osub_digit_step #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  input  logic          brw_in,
  input  logic [DW:0]   radix,
  output logic [DW-1:0] dig,
  output logic          brw_out
);
  localparam int XW = DW + 2;
  logic [XW-1:0] raw;
  logic [XW-1:0] wrapped;

  always_comb begin
    raw     = {2'b00, a_val} - {2'b00, b_val} - {{(XW-1){1'b0}}, brw_in};
    wrapped = raw + {1'b0, radix};
    brw_out = raw[XW-1];
    dig     = brw_out ? wrapped[DW-1:0] : raw[DW-1:0];
  end
endmodule

// File: rtl/osub_regfile.sv
// Digit storage: one write port, every entry readable in parallel.
module osub_regfile #(
  parameter int NDIG = 6,
  parameter int DW   = 4,
  parameter int AW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  output logic [NDIG*DW-1:0] flat
);
  logic [DW-1:0] mem [NDIG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NDIG; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_rd
    assign flat[g*DW +: DW] = mem[g];
  end
endmodule

// File: rtl/osub_msd.sv
// Finds the highest non-zero digit from index LO upward.
module osub_msd #(
  parameter int NDIG = 6,
  parameter int DW   = 4,
  parameter int LO   = 2
) (
  input  logic [NDIG*DW-1:0] flat,
  output logic [DW-1:0]      msd,
  output logic               none
);
  logic [NDIG-1:0] nz;

  for (genvar g = 0; g < NDIG; g++) begin : g_nz
    assign nz[g] = |flat[g*DW +: DW];
  end

  always_comb begin
    msd  = '0;
    none = 1'b1;
    for (int k = LO; k < NDIG; k++) begin
      if (nz[k]) begin
        msd  = flat[k*DW +: DW];
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/offset_subtractor.sv
module offset_subtractor #(
  parameter int NDIG        = osub_pkg::NUM_DIGITS,
  parameter int DW          = osub_pkg::DIGIT_W,
  parameter int PW          = 3,
  parameter int CFG_PERIOD  = osub_pkg::CFG_PERIOD,
  parameter int DEC_RADIX   = osub_pkg::DEC_RADIX,
  parameter int RESET_RADIX = 10,
  parameter int MSD_LO      = osub_pkg::MSD_LOW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PW-1:0]      period,
  input  logic [DW-1:0]      a_n,
  input  logic [DW-1:0]      b_n,
  input  logic               borrow_in,
  output logic [NDIG*DW-1:0] digits,
  output logic [DW-1:0]      msd,
  output logic               msd_none,
  output logic               borrow_out,
  output logic               borrow_valid
);
  localparam int AW   = $clog2(NDIG);
  localparam int RW   = DW + 1;
  localparam int LAST = NDIG - 1;

  logic [DW-1:0] a_val, b_val;
  logic          dig_load, cfg_load, first_p, last_p;
  logic [RW-1:0] radix_q, step_radix, radix_cfg;
  logic          chain_q, step_bin, step_bout;
  logic [DW-1:0] step_dig;
  logic [DW-1:0] msd_c;
  logic          none_c;

  assign a_val    = ~a_n;
  assign b_val    = ~b_n;
  assign first_p  = (period == '0);
  assign last_p   = (period == PW'(LAST));
  assign dig_load = load && (period < PW'(NDIG));
  assign cfg_load = load && (period == PW'(CFG_PERIOD));

  // Radix code 0 (bus all ones) selects the largest radix 2**DW.
  assign radix_cfg  = (a_val == '0) ? RW'(1 << DW) : {1'b0, a_val};
  assign step_radix = first_p ? radix_q : RW'(DEC_RADIX);
  assign step_bin   = first_p ? borrow_in : chain_q;

  osub_digit_step #(.DW(DW)) u_step (
    .a_val  (a_val),
    .b_val  (b_val),
    .brw_in (step_bin),
    .radix  (step_radix),
    .dig    (step_dig),
    .brw_out(step_bout)
  );

  osub_regfile #(.NDIG(NDIG), .DW(DW), .AW(AW)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (dig_load),
    .waddr(AW'(period)),
    .wdata(step_dig),
    .flat (digits)
  );

  osub_msd #(.NDIG(NDIG), .DW(DW), .LO(MSD_LO)) u_msd (
    .flat(digits),
    .msd (msd_c),
    .none(none_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      radix_q      <= RW'(RESET_RADIX);
      chain_q      <= 1'b0;
      borrow_out   <= 1'b0;
      borrow_valid <= 1'b0;
      msd          <= '0;
      msd_none     <= 1'b1;
    end else begin
      if (cfg_load) radix_q <= radix_cfg;
      if (dig_load) begin
        chain_q <= step_bout;
        if (first_p) borrow_valid <= 1'b0;
        if (last_p) begin
          borrow_out   <= step_bout;
          borrow_valid <= 1'b1;
        end
      end
      msd      <= msd_c;
      msd_none <= none_c;
    end
  end
endmodule

// File: rtl/osub_checker.sv
module osub_checker #(
  parameter int NDIG = 6,
  parameter int DW   = 4,
  parameter int PW   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               load,
  input logic [PW-1:0]      period,
  input logic [NDIG*DW-1:0] digits,
  input logic [DW-1:0]      msd,
  input logic               msd_none,
  input logic               borrow_out,
  input logic               borrow_valid
);
  p_valid_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (load && period == '0) |=> !borrow_valid);

  p_valid_set_r7: assert property (@(posedge clk) disable iff (rst)
    (load && period == PW'(NDIG-1)) |=> borrow_valid);

  p_bout_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(load && period == PW'(NDIG-1)) |=> $stable(borrow_out));

  p_digits_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(load && period < PW'(NDIG)) |=> $stable(digits));

  p_msd_flag_r9: assert property (@(posedge clk) disable iff (rst)
    msd_none |-> (msd == '0));
endmodule

bind offset_subtractor osub_checker #(.NDIG(NDIG), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .period(period), .digits(digits),
  .msd(msd), .msd_none(msd_none), .borrow_out(borrow_out),
  .borrow_valid(borrow_valid)
);

// File: tb/test_offset_subtractor.sv
module test_offset_subtractor;
  typedef int dig6_t [6];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [2:0]  period = '0;
  logic [3:0]  a_n = 4'hF;
  logic [3:0]  b_n = 4'hF;
  logic        borrow_in = 1'b0;
  logic [23:0] digits;
  logic [3:0]  msd;
  logic        msd_none, borrow_out, borrow_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  offset_subtractor i_offset_subtractor (
    .clk(clk), .rst(rst), .load(load), .period(period), .a_n(a_n), .b_n(b_n),
    .borrow_in(borrow_in), .digits(digits), .msd(msd), .msd_none(msd_none),
    .borrow_out(borrow_out), .borrow_valid(borrow_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int per, input int a, input int b, input bit bi);
    @(negedge clk);
    period    = 3'(per);
    a_n       = ~4'(a);
    b_n       = ~4'(b);
    borrow_in = bi;
    load      = 1'b1;
    @(negedge clk);
    load      = 1'b0;
    a_n       = 4'h5;
    b_n       = 4'hA;
    borrow_in = 1'b1;
  endtask

  // Radix M: code is M, except 16 which is code 0 (R8).
  task automatic set_radix(input int m);
    put(6, (m == 16) ? 0 : m, 0, 1'b0);
  endtask

  task automatic run_sub(input string tag, input dig6_t ad, input dig6_t bd,
                         input bit bi, input int m);
    int av, bv, p, r, em;
    int e [6];
    bit neg, enone;
    for (int k = 0; k < 6; k++) put(k, ad[k], bd[k], (k == 0) ? bi : 1'b0);
    repeat (2) @(negedge clk);
    av = ((((ad[5]*10 + ad[4])*10 + ad[3])*10 + ad[2])*10 + ad[1])*m + ad[0];
    bv = ((((bd[5]*10 + bd[4])*10 + bd[3])*10 + bd[2])*10 + bd[1])*m + bd[0];
    p = av - bv - int'(bi);
    neg = (p < 0);
    if (neg) p = p + m*100000;
    e[0] = p % m;
    r = p / m;
    for (int k = 1; k < 6; k++) begin e[k] = r % 10; r = r / 10; end
    em = 0; enone = 1'b1;
    for (int k = 2; k < 6; k++) if (e[k] != 0) begin em = e[k]; enone = 1'b0; end
    chk({tag, " R4 digit0"}, int'(digits[3:0]), e[0]);
    for (int k = 1; k < 6; k++) chk({tag, " R3 digit"}, int'(digits[k*4 +: 4]), e[k]);
    chk({tag, " R6 borrow_out"}, int'(borrow_out), int'(neg));
    chk({tag, " R7 borrow_valid"}, int'(borrow_valid), 1);
    chk({tag, " R9 msd"}, int'(msd), em);
    chk({tag, " R9 msd_none"}, int'(msd_none), int'(enone));
  endtask

  task automatic t_reset();
    chk("R1 digits", int'(digits), 0);
    chk("R1 borrow_out", int'(borrow_out), 0);
    chk("R1 borrow_valid", int'(borrow_valid), 0);
    chk("R1 msd", int'(msd), 0);
    chk("R1 msd_none", int'(msd_none), 1);
  endtask

  task automatic t_wrap_default_radix();
    run_sub("R6 R8 wrap M=10", '{0,0,0,0,0,0}, '{1,0,0,0,0,0}, 1'b0, 10);
  endtask

  task automatic t_inverted_plain();
    run_sub("R2 plain", '{7,4,6,8,2,3}, '{2,1,3,5,1,1}, 1'b0, 10);
  endtask

  task automatic t_ripple();
    run_sub("R3 ripple", '{0,0,0,0,0,1}, '{1,0,0,0,0,0}, 1'b0, 10);
  endtask

  task automatic t_borrow_in();
    run_sub("R5 bin", '{0,0,3,0,0,0}, '{0,0,0,0,0,0}, 1'b1, 10);
  endtask

  task automatic t_radix16();
    set_radix(16);
    run_sub("R8 M=16", '{3,5,0,0,1,0}, '{12,2,0,0,0,0}, 1'b0, 16);
    run_sub("R6 M=16 wrap", '{0,0,0,0,0,0}, '{0,0,0,0,0,1}, 1'b1, 16);
  endtask

  task automatic t_radix3();
    set_radix(3);
    run_sub("R4 M=3", '{0,5,0,4,0,0}, '{2,1,0,0,0,0}, 1'b0, 3);
  endtask

  task automatic t_msd_zero();
    set_radix(10);
    run_sub("R9 zero", '{5,3,0,0,0,0}, '{1,1,0,0,0,0}, 1'b0, 10);
  endtask

  task automatic t_valid_cycle();
    put(0, 4, 1, 1'b0);
    @(negedge clk);
    chk("R7 valid cleared", int'(borrow_valid), 0);
    chk("R7 borrow_out kept", int'(borrow_out), 0);
    for (int k = 1; k < 6; k++) put(k, 0, 0, 1'b0);
    @(negedge clk);
    chk("R7 valid set", int'(borrow_valid), 1);
    chk("R3 digit0 after cycle", int'(digits[3:0]), 3);
  endtask

  task automatic t_hold_and_p7();
    logic [23:0] snap;
    logic        sb;
    snap = digits; sb = borrow_out;
    @(negedge clk);
    a_n = 4'h0; b_n = 4'h3; period = 3'd2; borrow_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 digits held", int'(digits), int'(snap));
    chk("R10 borrow held", int'(borrow_out), int'(sb));
    put(7, 9, 1, 1'b1);
    repeat (2) @(negedge clk);
    chk("R11 digits held", int'(digits), int'(snap));
    chk("R11 valid held", int'(borrow_valid), 1);
    // M must still be 10 after the period-7 load
    run_sub("R11 radix kept", '{0,0,0,0,0,0}, '{1,0,0,0,0,0}, 1'b0, 10);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wrap_default_radix();
    t_inverted_plain();
    t_ripple();
    t_borrow_in();
    t_radix16();
    t_radix3();
    t_msd_zero();
    t_valid_cycle();
    t_hold_and_p7();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule